// File: doc/BRIEF.md
# Status-Flag Arithmetic and Logic Unit

This block is a combinational arithmetic and logic unit that keeps a registered 32-bit status word. It adds, adds with carry, subtracts, subtracts with borrow, and computes AND, OR, XOR and NOT. Operands can be 8, 16, 32 or 64 bits wide. The result appears in the same cycle as the inputs. The status word holds six condition bits, each at a fixed position: carry, even parity of the low byte, nibble adjust, zero, sign and signed overflow.

The status word updates on a rising clock edge only when the caller asserts the write enable and the operation is one that produces flags. Bits of the word that no operation produces keep their value. The reserved bit 1 always reads as one. The carry-in for add-with-carry and subtract-with-borrow comes from the stored carry bit, so multi-word arithmetic can be chained one word per cycle.

Top module: `stat_flags_alu`

## Requirements
- R1: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow. The result is the sum or difference modulo 2^W. Add-with-carry also adds the stored carry bit (bit 0). Subtract-with-borrow also subtracts the stored carry bit.
- R2: Operation codes are 4 AND, 5 OR, 6 XOR, 7 NOT (NOT inverts operand A). For every operation, result bits at or above the selected width read zero.
- R3: The 2-bit width select chooses W: 0 means 8, 1 means 16, 2 means 32, 3 means 64. Only the low W bits of the operands take part.
- R4: Carry (bit 0) is set when an add carries out of bit W-1, or when a subtract needs a borrow past bit W-1.
- R5: Parity (bit 2) is set when the low 8 result bits hold an even number of ones.
- R6: Adjust (bit 4) is set on a carry or borrow between bit 3 and bit 4 of an arithmetic operation.
- R7: Zero (bit 6) is set when the W-bit result is zero. Sign (bit 7) equals result bit W-1.
- R8: Overflow (bit 11) is set when the exact signed result of an arithmetic operation lies outside the W-bit two's-complement range.
- R9: AND, OR and XOR clear carry, adjust and overflow, and set zero, sign and parity from the result.
- R10: NOT leaves the whole status word unchanged and never raises the write strobe.
- R11: The status word loads on a rising edge only when the write enable is high and the operation is not NOT. The flag-write strobe output is high in exactly those cycles.
- R12: Reset sets the status word to 0x00000002. Bit 1 stays one, and every bit other than 0, 2, 4, 6, 7 and 11 keeps its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| width_i | input | 2 | Operand width select |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| flag_we_i | input | 1 | Status write enable |
| result_o | output | 64 | Result, zero above the selected width |
| flags_o | output | 32 | Registered status word |
| flags_wr_o | output | 1 | Status-word write strobe for this cycle |

## Verification
The bench runs every operation at every width. Its directed vectors sit at carry boundaries: all-ones plus one, zero minus one, and the most positive and most negative values. A design that taps the carry or sign from bit 63 regardless of the width would set the wrong carry, sign and overflow on narrow operands. One that returns the raw carry on subtracts would set carry where no borrow happened. Chained add-with-carry and subtract-with-borrow vectors with the stored carry set expose a carry-in that is ignored or has the wrong polarity, and nibble-edge vectors catch an adjust flag computed from the wrong bit. Vectors with the write enable low, and NOT with it high, catch a register that loads when it should hold, or that disturbs the reserved bit.

// File: rtl/sfa_pkg.sv
`timescale 1ns/1ps
package sfa_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
    OP_AND = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6, OP_NOT = 3'd7
  } sfa_op_e;

  localparam int FLAG_W  = 32;
  localparam int BIT_CF  = 0;
  localparam int BIT_RSV = 1;
  localparam int BIT_PF  = 2;
  localparam int BIT_AF  = 4;
  localparam int BIT_ZF  = 6;
  localparam int BIT_SF  = 7;
  localparam int BIT_OF  = 11;

  localparam logic [FLAG_W-1:0] FLAGS_RST = FLAG_W'(1) << BIT_RSV;
  localparam logic [FLAG_W-1:0] FLAG_UPD_MASK =
    (FLAG_W'(1) << BIT_CF) | (FLAG_W'(1) << BIT_PF) | (FLAG_W'(1) << BIT_AF) |
    (FLAG_W'(1) << BIT_ZF) | (FLAG_W'(1) << BIT_SF) | (FLAG_W'(1) << BIT_OF);
endpackage

// File: rtl/sfa_arith.sv
`timescale 1ns/1ps
module sfa_arith #(
  parameter int DW = 64,
  parameter int NW = 4
) (
  input  logic                  sub_i,
  input  logic                  cin_i,
  input  logic [DW-1:0]         a_i,
  input  logic [DW-1:0]         b_i,
  input  logic [$clog2(NW)-1:0] wsel_i,
  output logic [DW-1:0]         sum_o,
  output logic                  cout_o,
  output logic                  ovf_o
);
  logic [DW-1:0] b_eff;
  logic [DW-1:0] sum_w [NW];
  logic [NW-1:0] cout_w;
  logic [NW-1:0] ovf_w;

  // subtraction reuses the adder: invert B, carry-in supplies the +1
  assign b_eff = sub_i ? ~b_i : b_i;

  for (genvar gi = 0; gi < NW; gi++) begin : g_width
    localparam int W = 8 << gi;
    logic [W:0] s;
    assign s          = {1'b0, a_i[W-1:0]} + {1'b0, b_eff[W-1:0]} + {{W{1'b0}}, cin_i};
    assign sum_w[gi]  = DW'(s[W-1:0]);
    assign cout_w[gi] = s[W];
    assign ovf_w[gi]  = (a_i[W-1] == b_eff[W-1]) && (s[W-1] != a_i[W-1]);
  end

  always_comb begin
    sum_o  = sum_w[wsel_i];
    cout_o = cout_w[wsel_i];
    ovf_o  = ovf_w[wsel_i];
  end
endmodule

// File: rtl/sfa_logic.sv
`timescale 1ns/1ps
module sfa_logic #(
  parameter int DW = 64,
  parameter int NW = 4
) (
  input  logic [1:0]            fn_i,
  input  logic [DW-1:0]         a_i,
  input  logic [DW-1:0]         b_i,
  input  logic [$clog2(NW)-1:0] wsel_i,
  output logic [DW-1:0]         res_o
);
  logic [DW-1:0] mask_w [NW];
  logic [DW-1:0] raw;

  for (genvar gi = 0; gi < NW; gi++) begin : g_mask
    localparam int W = 8 << gi;
    assign mask_w[gi] = DW'({W{1'b1}});
  end

  // fn: 0 AND, 1 OR, 2 XOR, 3 NOT
  always_comb begin
    unique case (fn_i)
      2'd0:    raw = a_i & b_i;
      2'd1:    raw = a_i | b_i;
      2'd2:    raw = a_i ^ b_i;
      default: raw = ~a_i;
    endcase
    res_o = raw & mask_w[wsel_i];
  end
endmodule

// File: rtl/sfa_flagreg.sv
`timescale 1ns/1ps
module sfa_flagreg
  import sfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] upd_i,
  output logic [FLAG_W-1:0] flags_q
);
  logic              rst_meta;
  logic              rst_sync_n;
  logic [FLAG_W-1:0] flags_nxt;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    flags_nxt = flags_q;
    if (wr_i) flags_nxt = (upd_i & FLAG_UPD_MASK) | (flags_q & ~FLAG_UPD_MASK);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flags_q <= FLAGS_RST;
    else             flags_q <= flags_nxt;
  end

  AST_RSVD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[BIT_RSV] && ((flags_q & ~FLAG_UPD_MASK) == FLAGS_RST)); // R12
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(flags_q)); // R11
endmodule

// File: rtl/stat_flags_alu.sv
`timescale 1ns/1ps
module stat_flags_alu
  import sfa_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_i,
  input  logic [1:0]    width_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          flag_we_i,
  output logic [DW-1:0] result_o,
  output logic [31:0]   flags_o,
  output logic          flags_wr_o
);
  localparam int NW = $clog2(DW / 8) + 1;

  sfa_op_e       op;
  logic          is_arith;
  logic          is_sub;
  logic          cf_q;
  logic          cin;
  logic [DW-1:0] asum;
  logic          acout;
  logic          aovf;
  logic [DW-1:0] lres;
  logic [DW-1:0] res;
  logic [NW-1:0] msb_w;
  logic [FLAG_W-1:0] upd;
  logic [FLAG_W-1:0] flags_q;

  assign op       = sfa_op_e'(op_i);
  assign is_arith = !op_i[2];
  assign is_sub   = (op == OP_SUB) || (op == OP_SBB);
  assign cf_q     = flags_q[BIT_CF];

  always_comb begin
    unique case (op)
      OP_ADC:  cin = cf_q;
      OP_SUB:  cin = 1'b1;
      OP_SBB:  cin = ~cf_q;
      default: cin = 1'b0;
    endcase
  end

  sfa_arith #(.DW(DW), .NW(NW)) u_arith (
    .sub_i (is_sub), .cin_i (cin), .a_i (a_i), .b_i (b_i),
    .wsel_i(width_i[$clog2(NW)-1:0]),
    .sum_o (asum), .cout_o(acout), .ovf_o(aovf)
  );

  sfa_logic #(.DW(DW), .NW(NW)) u_logic (
    .fn_i (op_i[1:0]), .a_i (a_i), .b_i (b_i),
    .wsel_i(width_i[$clog2(NW)-1:0]), .res_o(lres)
  );

  assign res = is_arith ? asum : lres;

  for (genvar gi = 0; gi < NW; gi++) begin : g_sign
    assign msb_w[gi] = res[(8 << gi) - 1];
  end

  always_comb begin
    upd          = '0;
    upd[BIT_CF]  = is_arith && (is_sub ? ~acout : acout);
    upd[BIT_OF]  = is_arith && aovf;
    upd[BIT_AF]  = is_arith && (a_i[4] ^ b_i[4] ^ res[4]);
    upd[BIT_PF]  = ~^res[7:0];
    upd[BIT_ZF]  = (res == '0);
    upd[BIT_SF]  = msb_w[width_i[$clog2(NW)-1:0]];
  end

  assign flags_wr_o = flag_we_i && (op != OP_NOT);

  sfa_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .wr_i(flags_wr_o), .upd_i(upd), .flags_q(flags_q)
  );

  assign result_o = res;
  assign flags_o  = flags_q;

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (width_i != 2'd3) |-> ((result_o >> (8 << width_i)) == '0)); // R2
  AST_NOT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd7) |=> $stable(flags_o)); // R10
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && op_i[2] && (op_i != 3'd7)) |=>
      (!flags_o[BIT_CF] && !flags_o[BIT_OF] && !flags_o[BIT_AF])); // R9
  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && (op_i != 3'd7) && (result_o == '0)) |=>
      (flags_o[BIT_ZF] && !flags_o[BIT_SF])); // R7
endmodule

// File: tb/stat_flags_alu_test.sv
`timescale 1ns/1ps
module stat_flags_alu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op;
  logic [1:0]  wsel;
  logic [63:0] a, b;
  logic        we;
  logic [63:0] result;
  logic [31:0] flags;
  logic        fwr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [31:0] mf;

  always #5 clk = ~clk;

  stat_flags_alu uut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .width_i(wsel), .a_i(a), .b_i(b),
    .flag_we_i(we), .result_o(result), .flags_o(flags), .flags_wr_o(fwr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (op=%0d w=%0d a=%h b=%h)", tag, act, exp, op, wsel, a, b);
    end
  endtask

  // behavioural reference: exact integer arithmetic on the selected width
  task automatic model(input logic [2:0] o, input logic [1:0] w, input logic [63:0] x,
                       input logic [63:0] y, input logic [31:0] fin,
                       output logic [63:0] r, output logic [31:0] fout);
    int W = 8 << w;
    logic [64:0] m = (65'd1 << W) - 65'd1;
    logic [64:0] ux = {1'b0, x} & m;
    logic [64:0] uy = {1'b0, y} & m;
    logic [64:0] full;
    logic signed [67:0] sx, sy, ex, smax, smin;
    int cc = 0;
    int nib;
    logic cf = 1'b0, of = 1'b0, af = 1'b0;
    sx = $signed({3'b0, ux}); sy = $signed({3'b0, uy});
    if (ux[W-1]) sx = sx - (68'sd1 <<< W);
    if (uy[W-1]) sy = sy - (68'sd1 <<< W);
    smax = (68'sd1 <<< (W-1)) - 68'sd1;
    smin = -(68'sd1 <<< (W-1));
    if (o == 3'd1 || o == 3'd3) cc = int'(fin[0]);
    case (o)
      3'd0, 3'd1: begin
        full = ux + uy + 65'(cc);
        cf   = full[W];
        ex   = sx + sy + 68'(cc);
        nib  = int'(ux[3:0]) + int'(uy[3:0]) + cc;
        af   = nib > 15;
      end
      3'd2, 3'd3: begin
        full = ux - uy - 65'(cc);
        cf   = ux < (uy + 65'(cc));
        ex   = sx - sy - 68'(cc);
        af   = int'(ux[3:0]) < int'(uy[3:0]) + cc;
      end
      3'd4: full = ux & uy;
      3'd5: full = ux | uy;
      3'd6: full = ux ^ uy;
      default: full = ~ux;
    endcase
    full = full & m;
    r = full[63:0];
    if (o < 3'd4) of = (ex > smax) || (ex < smin);
    fout = fin;
    if (o != 3'd7) begin
      fout[0]  = cf;
      fout[2]  = ~^r[7:0];
      fout[4]  = af;
      fout[6]  = (r == 64'd0);
      fout[7]  = r[W-1];
      fout[11] = of;
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [1:0] w, input logic [63:0] x,
                      input logic [63:0] y, input logic e);
    logic [63:0] er;
    logic [31:0] ef;
    logic ewr;
    @(negedge clk);
    op = o; wsel = w; a = x; b = y; we = e;
    #1;
    model(o, w, x, y, mf, er, ef);
    ewr = e && (o != 3'd7);
    if (o < 3'd4) chk("R1 R3 result", result, er);
    else          chk("R2 R3 result", result, er);
    chk("R11 strobe", {63'd0, fwr}, {63'd0, ewr});
    @(posedge clk);
    #1;
    if (ewr) mf = ef;
    if (o == 3'd7)     chk("R10 flags unchanged", {32'd0, flags}, {32'd0, mf});
    else if (!e)       chk("R11 flags held", {32'd0, flags}, {32'd0, mf});
    else if (o >= 3'd4) begin
      chk("R9 carry/adjust/overflow", {61'd0, flags[0], flags[4], flags[11]},
          {61'd0, mf[0], mf[4], mf[11]});
    end else begin
      chk("R4 carry",    {63'd0, flags[0]},  {63'd0, mf[0]});
      chk("R6 adjust",   {63'd0, flags[4]},  {63'd0, mf[4]});
      chk("R8 overflow", {63'd0, flags[11]}, {63'd0, mf[11]});
    end
    chk("R5 parity", {63'd0, flags[2]}, {63'd0, mf[2]});
    chk("R7 zero",   {63'd0, flags[6]}, {63'd0, mf[6]});
    chk("R7 sign",   {63'd0, flags[7]}, {63'd0, mf[7]});
    chk("R12 other bits", {32'd0, flags & ~32'h08D5}, {32'd0, mf & ~32'h08D5});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op = 3'd0; wsel = 2'd0; a = '0; b = '0; we = 1'b0;
    mf = 32'h0000_0002;
    repeat (3) @(posedge clk);
    #1 chk("R12 reset word", {32'd0, flags}, 64'h2);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R12 after release", {32'd0, flags}, 64'h2);

    // R4 R6 R7 R5: 8-bit wrap to zero
    step(3'd0, 2'd0, 64'hFF, 64'h01, 1'b1);
    // R1 add-with-carry consumes carry from above
    step(3'd1, 2'd0, 64'h10, 64'h20, 1'b1);
    // R8 signed overflow at 8, 16, 32, 64
    step(3'd0, 2'd0, 64'h7F, 64'h01, 1'b1);
    step(3'd0, 2'd1, 64'h7FFF, 64'h0001, 1'b1);
    step(3'd0, 2'd2, 64'h8000_0000, 64'h8000_0000, 1'b1);
    step(3'd0, 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b1);
    // R4 borrow, then subtract-with-borrow chained
    step(3'd2, 2'd0, 64'h00, 64'h01, 1'b1);
    step(3'd3, 2'd0, 64'h05, 64'h05, 1'b1);
    step(3'd2, 2'd3, 64'h0, 64'h1, 1'b1);
    step(3'd3, 2'd3, 64'h8000_0000_0000_0000, 64'h0, 1'b1);
    step(3'd3, 2'd1, 64'h8000, 64'h7FFF, 1'b1);
    // R3 upper operand bits ignored for narrow widths
    step(3'd0, 2'd1, 64'hABCD_0000_0000_FFFF, 64'hFFFF_0000_0000_0001, 1'b1);
    // R6 nibble edge
    step(3'd0, 2'd2, 64'h0F, 64'h01, 1'b1);
    step(3'd2, 2'd2, 64'h10, 64'h01, 1'b1);
    // R9 logic ops after a carry-producing add
    step(3'd0, 2'd0, 64'hFF, 64'hFF, 1'b1);
    step(3'd4, 2'd0, 64'hF0, 64'h0F, 1'b1);
    step(3'd0, 2'd0, 64'h80, 64'h80, 1'b1);
    step(3'd5, 2'd3, 64'h8000_0000_0000_0000, 64'h3, 1'b1);
    step(3'd6, 2'd1, 64'h1234, 64'h1234, 1'b1);
    // R10 NOT leaves flags
    step(3'd7, 2'd2, 64'h0, 64'h0, 1'b1);
    step(3'd7, 2'd0, 64'hFF, 64'h0, 1'b1);
    // R11 no write when enable low
    step(3'd2, 2'd0, 64'h0, 64'h1, 1'b0);
    step(3'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0);
    // mixed patterns
    for (int i = 0; i < 600; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (i % 7 == 0) rb = ra;
      if (i % 11 == 0) ra = 64'hFFFF_FFFF_FFFF_FFFF;
      step(3'($urandom % 8), 2'($urandom % 4), ra, rb, ($urandom % 5) != 0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule